// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides whether a received CAN frame header is kept, and where it goes. It compares each header against a bank of filter objects. Every filter has its own mask, an enable bit and a target receive-queue number. The header consists of the 11-bit base identifier, the 18-bit identifier extension, the identifier-extension (IDE) flag and the first 18 payload bits. The bank uses a single 29-bit key per frame. For an extended frame the key is the full identifier {base, extension}. For a standard frame the key is the base identifier followed by the first 18 data bits. A filter can therefore target either extended identifiers or standard identifiers qualified by the start of the payload.

The receive path pulses a header-valid strobe once per frame. A fixed number of clock edges later, the bank pulses a result strobe. The strobe carries a hit flag, the index of the winning filter and that filter's target queue. A result without a hit tells the storage logic to drop the frame. The configuration inputs are expected to stay steady while frames are in flight.

Top module: `afb_filter_bank`

## Requirements
- R1: While `rst_n` is low and after its release, `res_valid`, `res_hit`, `res_idx` and `res_fifo` are all zero until the first result.
- R2: The bank samples `hdr_valid` high at a clock edge. Exactly two clock edges later, `res_valid` goes high for one cycle. Headers on consecutive cycles each produce their own result on consecutive cycles.
- R3: When `hdr_ide` is 0, the 29-bit key is {`hdr_sid`, `hdr_data`}, and `hdr_eid` has no effect. `hdr_data[17]` is the first payload bit received.
- R4: When `hdr_ide` is 1, the key is {`hdr_sid`, `hdr_eid`}, and `hdr_data` has no effect. Filter identifier bits [28:18] hold the base part and bits [17:0] hold the lower part.
- R5: A key bit takes part in the comparison only where the filter's mask bit is 1. Where the mask bit is 0, that key bit is don't-care.
- R6: When a filter's IDE mask bit is 1, the frame's IDE flag must equal the filter's IDE bit. When the IDE mask bit is 0, frames of either format can match.
- R7: A filter whose enable bit is 0 never matches.
- R8: When several enabled filters match, the one with the lowest index wins.
- R9: On a hit, `res_hit` is 1, `res_idx` is the winning filter's index and `res_fifo` is that filter's 5-bit target queue field.
- R10: When no enabled filter matches, the result strobe carries `res_hit` = 0, `res_idx` = 0 and `res_fifo` = 0, which means the frame is discarded.
- R11: `res_hit`, `res_idx` and `res_fifo` keep their values in every cycle where `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| hdr_valid | input | 1 | One-cycle strobe: header fields are valid |
| hdr_ide | input | 1 | Frame IDE flag, 1 = extended identifier |
| hdr_sid | input | 11 | Base identifier |
| hdr_eid | input | 18 | Identifier extension |
| hdr_data | input | 18 | First 18 payload bits, first received in bit 17 |
| cfg_en | input | 32 | Per-filter enable, bit i for filter i |
| cfg_flt_ide | input | 32 | Per-filter IDE value to match |
| cfg_msk_ide | input | 32 | Per-filter IDE compare enable |
| cfg_flt_id | input | 928 | 29-bit filter key per filter, filter i at [29i+28:29i] |
| cfg_msk_id | input | 928 | 29-bit mask per filter, same layout |
| cfg_fifo | input | 160 | 5-bit target queue per filter, filter i at [5i+4:5i] |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Frame accepted by some enabled filter |
| res_idx | output | 5 | Index of the winning filter |
| res_fifo | output | 5 | Target queue of the winning filter |

## Verification
The assertions check on every cycle that each result strobe arrives exactly two edges after its header strobe, with no extra strobes, and that result fields hold between strobes. They also check that a hit names an enabled filter and carries that filter's queue field, and that a miss carries zero fields. The bench's scenarios are the only checks that show the compare logic itself. They cover the key selection for standard and extended frames, the effect of individual mask bits and of the IDE mask bit, and which filter wins when several enabled filters match, including the highest index.

// File: rtl/afb_pkg.sv
package afb_pkg;
  localparam int SID_W = 11;
  localparam int LOW_W = 18;
  localparam int KEY_W = SID_W + LOW_W;

  typedef struct packed {
    logic             ide;
    logic [KEY_W-1:0] id;
  } afb_key_t;
endpackage

// File: rtl/afb_match_unit.sv
module afb_match_unit
  import afb_pkg::*;
(
  input  afb_key_t         key,
  input  logic             flt_ide,
  input  logic             msk_ide,
  input  logic [KEY_W-1:0] flt_id,
  input  logic [KEY_W-1:0] msk_id,
  output logic             hit
);
  logic id_ok;
  logic ide_ok;

  always_comb begin
    id_ok  = ((key.id ^ flt_id) & msk_id) == '0;
    ide_ok = !msk_ide || (key.ide == flt_ide);
    hit    = id_ok && ide_ok;
  end
endmodule

// File: rtl/afb_prio_enc.sv
module afb_prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/afb_filter_bank.sv
module afb_filter_bank
  import afb_pkg::*;
#(
  parameter int NUM_FILT = 32,
  parameter int FIFO_W   = 5,
  parameter int IDX_W    = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hdr_valid,
  input  logic                       hdr_ide,
  input  logic [SID_W-1:0]           hdr_sid,
  input  logic [LOW_W-1:0]           hdr_eid,
  input  logic [LOW_W-1:0]           hdr_data,
  input  logic [NUM_FILT-1:0]        cfg_en,
  input  logic [NUM_FILT-1:0]        cfg_flt_ide,
  input  logic [NUM_FILT-1:0]        cfg_msk_ide,
  input  logic [NUM_FILT*KEY_W-1:0]  cfg_flt_id,
  input  logic [NUM_FILT*KEY_W-1:0]  cfg_msk_id,
  input  logic [NUM_FILT*FIFO_W-1:0] cfg_fifo,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic [IDX_W-1:0]           res_idx,
  output logic [FIFO_W-1:0]          res_fifo
);
  // stage 1: header capture
  afb_key_t key_q, key_d;
  logic     s1_vld_q;

  // stage 2: per-filter hit vector
  logic [NUM_FILT-1:0] hit_raw;
  logic [NUM_FILT-1:0] hit_q, hit_d;
  logic                s2_vld_q;

  // stage 3: encoded result
  logic              enc_any;
  logic [IDX_W-1:0]  enc_idx;
  logic              hit_res_d;
  logic [IDX_W-1:0]  idx_res_d;
  logic [FIFO_W-1:0] fifo_res_d;

  always_comb begin
    key_d = key_q;
    if (hdr_valid) begin
      key_d.ide = hdr_ide;
      key_d.id  = {hdr_sid, (hdr_ide ? hdr_eid : hdr_data)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q    <= '0;
      s1_vld_q <= 1'b0;
    end else begin
      key_q    <= key_d;
      s1_vld_q <= hdr_valid;
    end
  end

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    afb_match_unit u_match (
      .key     (key_q),
      .flt_ide (cfg_flt_ide[g]),
      .msk_ide (cfg_msk_ide[g]),
      .flt_id  (cfg_flt_id[g*KEY_W +: KEY_W]),
      .msk_id  (cfg_msk_id[g*KEY_W +: KEY_W]),
      .hit     (hit_raw[g])
    );
  end

  always_comb begin
    hit_d = hit_q;
    if (s1_vld_q) hit_d = hit_raw & cfg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q    <= '0;
      s2_vld_q <= 1'b0;
    end else begin
      hit_q    <= hit_d;
      s2_vld_q <= s1_vld_q;
    end
  end

  afb_prio_enc #(.N(NUM_FILT), .IDX_W(IDX_W)) u_enc (
    .vec (hit_q),
    .any (enc_any),
    .idx (enc_idx)
  );

  always_comb begin
    hit_res_d  = res_hit;
    idx_res_d  = res_idx;
    fifo_res_d = res_fifo;
    if (s2_vld_q) begin
      hit_res_d  = enc_any;
      idx_res_d  = enc_any ? enc_idx : '0;
      fifo_res_d = enc_any ? cfg_fifo[enc_idx*FIFO_W +: FIFO_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_fifo  <= '0;
    end else begin
      res_valid <= s2_vld_q;
      res_hit   <= hit_res_d;
      res_idx   <= idx_res_d;
      res_fifo  <= fifo_res_d;
    end
  end
endmodule

// File: rtl/afb_filter_bank_chk.sv
module afb_filter_bank_chk #(
  parameter int NUM_FILT = 32,
  parameter int FIFO_W   = 5,
  parameter int IDX_W    = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hdr_valid,
  input logic [NUM_FILT-1:0]        cfg_en,
  input logic [NUM_FILT*FIFO_W-1:0] cfg_fifo,
  input logic                       res_valid,
  input logic                       res_hit,
  input logic [IDX_W-1:0]           res_idx,
  input logic [FIFO_W-1:0]          res_fifo
);
  logic                       hv1, hv2, hv3;
  logic [NUM_FILT-1:0]        en_d1, en_d2;
  logic [NUM_FILT*FIFO_W-1:0] fifo_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv1     <= 1'b0;
      hv2     <= 1'b0;
      hv3     <= 1'b0;
      en_d1   <= '0;
      en_d2   <= '0;
      fifo_d1 <= '0;
    end else begin
      hv1     <= hdr_valid;
      hv2     <= hv1;
      hv3     <= hv2;
      en_d1   <= cfg_en;
      en_d2   <= en_d1;
      fifo_d1 <= cfg_fifo;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == hv3); // R2

  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> en_d2[res_idx]); // R7

  AST_FIFO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_fifo == fifo_d1[res_idx*FIFO_W +: FIFO_W])); // R9

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == '0 && res_fifo == '0)); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_hit) && $stable(res_idx) && $stable(res_fifo))); // R11
endmodule

bind afb_filter_bank afb_filter_bank_chk #(
  .NUM_FILT (NUM_FILT),
  .FIFO_W   (FIFO_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hdr_valid (hdr_valid),
  .cfg_en    (cfg_en),
  .cfg_fifo  (cfg_fifo),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_idx   (res_idx),
  .res_fifo  (res_fifo)
);

// File: tb/afb_filter_bank_test.sv
module afb_filter_bank_test;
  localparam int N  = 32;
  localparam int FW = 5;
  localparam int KW = 29;
  localparam logic [KW-1:0] ALL1 = {KW{1'b1}};

  logic          clk;
  logic          rst_n;
  logic          hdr_valid;
  logic          hdr_ide;
  logic [10:0]   hdr_sid;
  logic [17:0]   hdr_eid;
  logic [17:0]   hdr_data;
  logic [N-1:0]  cfg_en, cfg_flt_ide, cfg_msk_ide;
  logic [N*KW-1:0] cfg_flt_id, cfg_msk_id;
  logic [N*FW-1:0] cfg_fifo;
  logic          res_valid, res_hit;
  logic [4:0]    res_idx;
  logic [FW-1:0] res_fifo;

  int n_chk;
  int n_fail;
  bit done;

  afb_filter_bank uut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ide(hdr_ide),
    .hdr_sid(hdr_sid), .hdr_eid(hdr_eid), .hdr_data(hdr_data),
    .cfg_en(cfg_en), .cfg_flt_ide(cfg_flt_ide), .cfg_msk_ide(cfg_msk_ide),
    .cfg_flt_id(cfg_flt_id), .cfg_msk_id(cfg_msk_id), .cfg_fifo(cfg_fifo),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_fifo(res_fifo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_cfg();
    cfg_en = '0; cfg_flt_ide = '0; cfg_msk_ide = '0;
    cfg_flt_id = '0; cfg_msk_id = '0; cfg_fifo = '0;
  endtask

  task automatic set_flt(input int i, input bit en, input bit ide, input bit mide,
                         input logic [KW-1:0] id, input logic [KW-1:0] msk,
                         input logic [FW-1:0] fifo);
    cfg_en[i] = en; cfg_flt_ide[i] = ide; cfg_msk_ide[i] = mide;
    cfg_flt_id[i*KW +: KW] = id; cfg_msk_id[i*KW +: KW] = msk;
    cfg_fifo[i*FW +: FW] = fifo;
  endtask

  task automatic drive(input logic [10:0] sid, input logic [17:0] eid,
                       input logic [17:0] data, input bit ide);
    hdr_valid = 1'b1; hdr_sid = sid; hdr_eid = eid; hdr_data = data; hdr_ide = ide;
  endtask

  task automatic check_res(input bit hit, input int idx, input int fifo, input string tag);
    chk(res_valid == 1'b1, "R2", "res_valid at result", res_valid, 1);
    chk(res_hit == hit, tag, "res_hit", res_hit, hit);
    chk(res_idx == idx, tag, "res_idx", res_idx, idx);
    chk(res_fifo == fifo, tag, "res_fifo", res_fifo, fifo);
  endtask

  // drive one header; result expected two edges after the sampling edge
  task automatic run_frame(input logic [10:0] sid, input logic [17:0] eid,
                           input logic [17:0] data, input bit ide,
                           input bit hit, input int idx, input int fifo,
                           input string tag);
    @(negedge clk); drive(sid, eid, data, ide);
    @(negedge clk); hdr_valid = 1'b0;
    chk(res_valid == 1'b0, "R2", "res_valid one edge after", res_valid, 0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R2", "res_valid early", res_valid, 0);
    @(negedge clk);
    check_res(hit, idx, fifo, tag);
    @(negedge clk);
    chk(res_valid == 1'b0, "R2", "res_valid single pulse", res_valid, 0);
    chk(res_idx == idx && res_fifo == fifo && res_hit == hit, "R11",
        "held fields", {res_hit, res_idx, res_fifo}, {hit, 5'(idx), 5'(fifo)});
  endtask

  task automatic t_reset();
    chk(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
    chk(res_hit == 1'b0, "R1", "res_hit", res_hit, 0);
    chk(res_idx == '0 && res_fifo == '0, "R1", "idx/fifo", {res_idx, res_fifo}, 0);
  endtask

  task automatic t_standard();
    clear_cfg();
    set_flt(3, 1, 0, 1, {11'h123, 18'h2AAAA}, ALL1, 5'd7);
    // R3: standard key uses data bits, eid ignored
    run_frame(11'h123, 18'h3FFFF, 18'h2AAAA, 0, 1, 3, 7, "R3");
    run_frame(11'h123, 18'h2AAAA, 18'h2AAAB, 0, 0, 0, 0, "R3");
    run_frame(11'h124, 18'h0, 18'h2AAAA, 0, 0, 0, 0, "R10");
  endtask

  task automatic t_extended();
    clear_cfg();
    set_flt(5, 1, 1, 1, {11'h7F0, 18'h15555}, ALL1, 5'd12);
    // R4: extended key uses eid, data ignored
    run_frame(11'h7F0, 18'h15555, 18'h3FFFF, 1, 1, 5, 12, "R4");
    run_frame(11'h7F0, 18'h15554, 18'h15555, 1, 0, 0, 0, "R4");
    // R6: same key bits with IDE 0 rejected when IDE is compared
    run_frame(11'h7F0, 18'h0, 18'h15555, 0, 0, 0, 0, "R6");
  endtask

  task automatic t_mask();
    clear_cfg();
    set_flt(2, 1, 0, 0, {11'h500, 18'h0}, {11'h700, 18'h0}, 5'd3);
    run_frame(11'h5AB, 18'h00003, 18'h0, 1, 1, 2, 3, "R5");
    run_frame(11'h5FF, 18'h0, 18'h12345, 0, 1, 2, 3, "R6");
    run_frame(11'h3AB, 18'h0, 18'h0, 0, 0, 0, 0, "R5");
  endtask

  task automatic t_priority();
    clear_cfg();
    set_flt(4, 1, 0, 0, '0, '0, 5'd11);
    set_flt(9, 1, 0, 0, '0, '0, 5'd22);
    set_flt(20, 1, 0, 0, '0, '0, 5'd30);
    set_flt(31, 0, 0, 0, '0, '0, 5'd17);
    run_frame(11'h001, 18'h1, 18'h1, 1, 1, 4, 11, "R8");
    cfg_en[4] = 1'b0;
    run_frame(11'h001, 18'h1, 18'h1, 1, 1, 9, 22, "R7");
    cfg_en = '0; cfg_en[31] = 1'b1;
    run_frame(11'h7FF, 18'h3FFFF, 18'h0, 1, 1, 31, 17, "R9");
    cfg_en = '0;
    run_frame(11'h7FF, 18'h3FFFF, 18'h0, 1, 0, 0, 0, "R7");
  endtask

  task automatic t_back_to_back();
    clear_cfg();
    set_flt(9, 1, 1, 1, '0, '0, 5'd22);
    set_flt(20, 1, 0, 1, '0, '0, 5'd30);
    @(negedge clk); drive(11'h010, 18'h1, 18'h0, 1);
    @(negedge clk); drive(11'h020, 18'h0, 18'h2, 0);
    @(negedge clk); hdr_valid = 1'b0;
    chk(res_valid == 1'b0, "R2", "res_valid before first result", res_valid, 0);
    @(negedge clk);
    check_res(1, 9, 22, "R6");
    @(negedge clk);
    check_res(1, 20, 30, "R6");
    @(negedge clk);
    chk(res_valid == 1'b0, "R2", "res_valid after pair", res_valid, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; hdr_valid = 1'b0; hdr_ide = 1'b0;
    hdr_sid = '0; hdr_eid = '0; hdr_data = '0;
    clear_cfg();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_standard();
    t_extended();
    t_mask();
    t_priority();
    t_back_to_back();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule